// File: doc/BRIEF.md
# Loop-Count Ring Consumer

This block is the reading side of a descriptor ring kept in shared memory. A producer fills fixed-size entries, each several words long, and stamps the last word of every entry with a 4-bit lap tag. The consumer holds a word-granular tail pointer and the lap tag it expects to see next. An entry counts as ready only when its stamped tag matches that expectation. Stale data from the previous lap carries the old tag and is therefore rejected without any head comparison.

The entry at the tail is always on view: `entry_addr` and `entry_ok` form a continuous peek that never moves anything. A `get_req` pulse consumes the viewed entry. The tail advances by the entry size modulo the ring size, which need not be a power of two, and the expected tag steps on each wrap. A separate occupancy query turns a head pointer into a count of ready entries. That head is either a freshly sampled hardware head, which is also cached, or the cached copy. An end-of-session pulse copies the tail to a published pointer register for the producer.

Top module: `ring_consumer`

## Requirements
- R1: After reset the tail, published tail, cached head and reported count are 0 and the expected lap tag is 1, so an all-zero memory reads as not ready (`entry_ok`=0).
- R2: `mem_addr` equals tail + entry_words - 1, and `entry_ok` is 1 exactly when bits [31:28] of `mem_rdata` equal the expected lap tag.
- R3: Without `get_req`, `entry_addr` (the tail) and the expected tag hold across any number of cycles (peek does not advance).
- R4: `get_req` while `entry_ok`=1 moves the tail to (tail + entry_words) mod ring_words on the next clock.
- R5: `get_req` while `entry_ok`=0 leaves the tail and the expected tag unchanged.
- R6: The expected tag increments only when the new tail is 0 and wraps from 15 to 0.
- R7: One cycle after `count_req`, `valid_cnt` equals (head - tail)/entry_words when head >= tail, else (ring_words - tail + head)/entry_words, using the tail before any same-cycle advance.
- R8: With `count_sync`=1 the head is `hw_head`, which is also stored as the cached head; with `count_sync`=0 the cached head is used and `hw_head` is ignored.
- R9: One cycle after `end_req`, `pub_tail` equals the tail seen in the `end_req` cycle, before any same-cycle advance.
- R10: Rings whose word count is not a power of two (for example 15 words of 3-word entries) wrap correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ring_words | input | AW | Ring size in words, a multiple of cfg_entry_words |
| cfg_entry_words | input | AW | Entry size in words |
| mem_addr | output | AW | Word address of the tail entry's last word |
| mem_rdata | input | DW | Memory word at mem_addr (same-cycle read) |
| get_req | input | 1 | Consume the tail entry if ready |
| entry_ok | output | 1 | Tail entry is ready |
| entry_addr | output | AW | Word address of the tail entry |
| count_req | input | 1 | Compute the ready-entry count |
| count_sync | input | 1 | Take the head from hw_head and cache it |
| hw_head | input | AW | Live head pointer from the producer |
| valid_cnt | output | AW | Last computed ready-entry count |
| end_req | input | 1 | Publish the current tail |
| pub_tail | output | AW | Published tail pointer |

## Verification
A wrong tail shows at once on `entry_addr` and `mem_addr`, and a wrong expected tag flips `entry_ok` the moment the producer writes the next lap. The bench therefore runs sixteen full laps, so that a tag that fails to wrap at 15 or steps on a non-zero tail is exposed within one lap. A cached head that was not refreshed, or was refreshed without sync, shows one cycle after the next unsynced count query. A publish that samples the post-advance tail differs from the expected value in the cycle right after a combined get and end pulse.

// File: rtl/rc_pkg.sv
package rc_pkg;
    localparam int RC_TAG_LSB = 28;
    localparam int RC_TAG_W   = 4;
    localparam int RC_TAG_RST = 1;
endpackage

// File: rtl/rc_wrap_step.sv
module rc_wrap_step #(
    parameter int AW = 10
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] size,
    output logic [AW-1:0] nxt,
    output logic          wrapped
);
    logic [AW:0] sum;

    always_comb begin
        sum = {1'b0, base} + {1'b0, step};
        if (sum >= {1'b0, size}) begin
            sum = sum - {1'b0, size};
        end
        nxt     = sum[AW-1:0];
        wrapped = (sum[AW-1:0] == '0);
    end
endmodule

// File: rtl/rc_tag_match.sv
module rc_tag_match #(
    parameter int DW    = 32,
    parameter int TAG_L = 28,
    parameter int TAG_W = 4
) (
    input  logic [DW-1:0]    word,
    input  logic [TAG_W-1:0] expect_tag,
    output logic             match
);
    localparam logic [DW-1:0] MASK = DW'((1 << TAG_W) - 1);
    logic [DW-1:0] field;

    always_comb begin
        field = (word >> TAG_L) & MASK;
        match = (field == {{(DW-TAG_W){1'b0}}, expect_tag});
    end
endmodule

// File: rtl/rc_occupancy.sv
module rc_occupancy #(
    parameter int AW = 10
) (
    input  logic [AW-1:0] head,
    input  logic [AW-1:0] tail,
    input  logic [AW-1:0] size,
    input  logic [AW-1:0] step,
    output logic [AW-1:0] count
);
    logic [AW-1:0] span;

    always_comb begin
        if (head >= tail) begin
            span = head - tail;
        end else begin
            span = size - tail + head;
        end
        if (step == '0) begin
            count = '0;
        end else begin
            count = span / step;
        end
    end
endmodule

// File: rtl/ring_consumer.sv
module ring_consumer
    import rc_pkg::*;
#(
    parameter int AW    = 10,
    parameter int DW    = 32,
    parameter int TAG_L = RC_TAG_LSB,
    parameter int TAG_W = RC_TAG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_ring_words,
    input  logic [AW-1:0] cfg_entry_words,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    input  logic          get_req,
    output logic          entry_ok,
    output logic [AW-1:0] entry_addr,
    input  logic          count_req,
    input  logic          count_sync,
    input  logic [AW-1:0] hw_head,
    output logic [AW-1:0] valid_cnt,
    input  logic          end_req,
    output logic [AW-1:0] pub_tail
);
    typedef struct packed {
        logic [AW-1:0]    tail;
        logic [TAG_W-1:0] tag;
        logic [AW-1:0]    hp;
        logic [AW-1:0]    cnt;
        logic [AW-1:0]    pub;
    } st_t;

    st_t st_d, st_q;

    logic [AW-1:0]    tail_nxt;
    logic             tail_wrap;
    logic             tag_hit;
    logic [AW-1:0]    head_sel;
    logic [AW-1:0]    occ;
    logic [AW-1:0]    tail_q;
    logic [TAG_W-1:0] tag_q;
    logic [AW-1:0]    hp_q;

    assign tail_q = st_q.tail;
    assign tag_q  = st_q.tag;
    assign hp_q   = st_q.hp;

    assign mem_addr   = st_q.tail + cfg_entry_words - AW'(1);
    assign entry_addr = st_q.tail;
    assign entry_ok   = tag_hit;
    assign valid_cnt  = st_q.cnt;
    assign pub_tail   = st_q.pub;
    assign head_sel   = count_sync ? hw_head : st_q.hp;

    rc_tag_match #(.DW(DW), .TAG_L(TAG_L), .TAG_W(TAG_W)) u_match (
        .word       (mem_rdata),
        .expect_tag (st_q.tag),
        .match      (tag_hit)
    );

    rc_wrap_step #(.AW(AW)) u_step (
        .base    (st_q.tail),
        .step    (cfg_entry_words),
        .size    (cfg_ring_words),
        .nxt     (tail_nxt),
        .wrapped (tail_wrap)
    );

    rc_occupancy #(.AW(AW)) u_occ (
        .head  (head_sel),
        .tail  (st_q.tail),
        .size  (cfg_ring_words),
        .step  (cfg_entry_words),
        .count (occ)
    );

    always_comb begin
        st_d = st_q;
        if (get_req && tag_hit) begin
            st_d.tail = tail_nxt;
            if (tail_wrap) begin
                st_d.tag = st_q.tag + TAG_W'(1);
            end
        end
        if (count_req) begin
            st_d.cnt = occ;
            if (count_sync) begin
                st_d.hp = hw_head;
            end
        end
        if (end_req) begin
            st_d.pub = st_q.tail;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tail <= '0;
            st_q.tag  <= TAG_W'(RC_TAG_RST);
            st_q.hp   <= '0;
            st_q.cnt  <= '0;
            st_q.pub  <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
    parameter int AW    = 10,
    parameter int TAG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    cfg_ring_words,
    input logic [AW-1:0]    cfg_entry_words,
    input logic             get_req,
    input logic             entry_ok,
    input logic             count_req,
    input logic             count_sync,
    input logic [AW-1:0]    hw_head,
    input logic             end_req,
    input logic [AW-1:0]    pub_tail,
    input logic [AW-1:0]    tail,
    input logic [TAG_W-1:0] tag,
    input logic [AW-1:0]    hp
);
    logic [AW:0] sum_w;
    assign sum_w = {1'b0, tail} + {1'b0, cfg_entry_words};

    p_invalid_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (get_req && !entry_ok) |=> ($stable(tail) && $stable(tag)));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!get_req) |=> ($stable(tail) && $stable(tag)));

    p_wrap_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (get_req && entry_ok && (sum_w >= {1'b0, cfg_ring_words}))
        |=> (tag == TAG_W'($past(tag) + TAG_W'(1))) && (tail == '0));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (get_req && entry_ok && (sum_w < {1'b0, cfg_ring_words}))
        |=> $stable(tag) && (tail == $past(tail) + $past(cfg_entry_words)));

    p_tail_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tail < cfg_ring_words));

    p_publish_r9: assert property (@(posedge clk) disable iff (!rst_n)
        end_req |=> (pub_tail == $past(tail)));

    p_sync_cache_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (count_req && count_sync) |=> (hp == $past(hw_head)));

    p_nosync_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(count_req && count_sync) |=> $stable(hp));
endmodule

bind ring_consumer rc_checker #(.AW(AW), .TAG_W(TAG_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_ring_words  (cfg_ring_words),
    .cfg_entry_words (cfg_entry_words),
    .get_req         (get_req),
    .entry_ok        (entry_ok),
    .count_req       (count_req),
    .count_sync      (count_sync),
    .hw_head         (hw_head),
    .end_req         (end_req),
    .pub_tail        (pub_tail),
    .tail            (tail_q),
    .tag             (tag_q),
    .hp              (hp_q)
);

// File: tb/sim_ring_consumer.sv
`timescale 1ns/1ps
module sim_ring_consumer;
    localparam int AW = 10;
    localparam int EW = 3;
    localparam int RW = 15;
    localparam int NE = RW / EW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_ring_words = AW'(RW);
    logic [AW-1:0] cfg_entry_words = AW'(EW);
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata;
    logic          get_req = 1'b0;
    logic          entry_ok;
    logic [AW-1:0] entry_addr;
    logic          count_req = 1'b0;
    logic          count_sync = 1'b0;
    logic [AW-1:0] hw_head = '0;
    logic [AW-1:0] valid_cnt;
    logic          end_req = 1'b0;
    logic [AW-1:0] pub_tail;

    logic [31:0] mem [0:63];
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;
    assign mem_rdata = mem[mem_addr[5:0]];

    ring_consumer u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_ring_words(cfg_ring_words), .cfg_entry_words(cfg_entry_words),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .get_req(get_req), .entry_ok(entry_ok), .entry_addr(entry_addr),
        .count_req(count_req), .count_sync(count_sync), .hw_head(hw_head),
        .valid_cnt(valid_cnt), .end_req(end_req), .pub_tail(pub_tail)
    );

    // walk table: {expected entry_ok, expected entry_addr} before each get
    localparam logic [15:0] WALK [0:5] = '{
        {6'd0, 1'b1, 9'd0}, {6'd0, 1'b1, 9'd3}, {6'd0, 1'b1, 9'd6},
        {6'd0, 1'b1, 9'd9}, {6'd0, 1'b1, 9'd12}, {6'd0, 1'b0, 9'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic stamp(input int ent, input int tagv);
        mem[ent*EW]     = 32'h0000_1000 + ent;
        mem[ent*EW + 1] = 32'h0000_2000 + ent;
        mem[ent*EW + 2] = {tagv[3:0], 28'h0ABC000 + 28'(ent)};
    endtask

    task automatic do_get(input logic with_end);
        @(negedge clk);
        get_req = 1'b1;
        end_req = with_end;
        @(negedge clk);
        get_req = 1'b0;
        end_req = 1'b0;
    endtask

    task automatic do_count(input logic sync, input int head);
        @(negedge clk);
        count_req  = 1'b1;
        count_sync = sync;
        hw_head    = AW'(head);
        @(negedge clk);
        count_req  = 1'b0;
        count_sync = 1'b0;
        hw_head    = AW'(0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 entry_ok", int'(entry_ok), 0);
        check("R1 entry_addr", int'(entry_addr), 0);
        check("R1 pub_tail", int'(pub_tail), 0);
        check("R1 valid_cnt", int'(valid_cnt), 0);
        check("R2 mem_addr", int'(mem_addr), EW - 1);
        // R5 get on invalid entry has no effect
        do_get(1'b0);
        check("R5 tail after invalid get", int'(entry_addr), 0);
        // R2 stamp lap tag 1 -> ready
        for (int e = 0; e < NE; e++) stamp(e, 1);
        #1;
        check("R2 entry_ok tag match", int'(entry_ok), 1);
        // R3 peek holds
        repeat (3) @(negedge clk);
        check("R3 peek addr hold", int'(entry_addr), 0);
        check("R3 peek ok hold", int'(entry_ok), 1);
        // R7 R8 synced count then cached count
        do_count(1'b1, 9);
        check("R7 count sync", int'(valid_cnt), 3);
        do_count(1'b0, 12);
        check("R8 cached head used", int'(valid_cnt), 3);
        // R4 R10 table walk through one lap
        for (int v = 0; v < 6; v++) begin
            check("R4 walk ok", int'(entry_ok), int'(WALK[v][9]));
            check("R4 walk addr", int'(entry_addr), int'(WALK[v][8:0]));
            do_get(1'b0);
        end
        // R6 after wrap tag expected 2, stale tag-1 entry rejected
        check("R6 stale entry rejected", int'(entry_ok), 0);
        check("R10 tail back to 0", int'(entry_addr), 0);
        for (int e = 0; e < NE; e++) stamp(e, 2);
        for (int g = 0; g < 4; g++) do_get(1'b0);
        check("R4 tail at last entry", int'(entry_addr), 12);
        do_count(1'b0, 0);
        check("R7 count wrapped span", int'(valid_cnt), 4);
        // R9 publish with same-cycle get
        do_get(1'b1);
        check("R9 pub pre-advance tail", int'(pub_tail), 12);
        check("R10 wrap 12->0", int'(entry_addr), 0);
        check("R6 tag moved past 2", int'(entry_ok), 0);
        // R6 sixteen laps crossing tag 15 -> 0
        for (int lap = 3; lap < 19; lap++) begin
            check("R6 stale before lap", int'(entry_ok), 0);
            for (int e = 0; e < NE; e++) stamp(e, lap & 15);
            #1;
            for (int e = 0; e < NE; e++) begin
                check("R6 lap entry ok", int'(entry_ok), 1);
                check("R4 lap entry addr", int'(entry_addr), e * EW);
                do_get(1'b0);
            end
        end
        // R7 empty ring: synced head equals tail
        do_count(1'b1, 0);
        check("R7 head equals tail", int'(valid_cnt), 0);
        @(negedge clk);
        end_req = 1'b1;
        @(negedge clk);
        end_req = 1'b0;
        check("R9 pub idle tail", int'(pub_tail), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule